// File: doc/BRIEF.md
# Jump Unit with Delay Slot

This unit computes the fetch address stream and the return-address write for unconditional jumps in a 32-bit pipelined core that has one architectural branch delay slot. Each cycle it presents a fetch address. When the instruction at that address is a jump, decode gives it the jump kind, a 26-bit immediate, the value and index of the source register, and an optional link destination index.

The unit always lets the next sequential instruction, the delay slot, issue first. The cycle after that, it redirects fetch to the target. The target is captured when the jump is accepted. Immediate jumps build the target from the immediate and the upper bits of the delay-slot address. Register jumps use the full 32-bit operand.

Linking jumps emit a one-cycle register-file write. The return address points past the delay slot. Two cases pulse error outputs instead of doing the normal work: a register-link jump whose source and destination collide, and a jump found in a delay slot. A stall input freezes the fetch address and any pending redirect.

Top module: `jump_unit`

## Requirements
- R1: While rst_ni is low, pc_o is 0x0000_0000 and wb_en_o, illegal_o and nested_o are 0.
- R2: In a cycle with stall_i low, no jump accepted and no redirect pending, pc_o advances by 4 at the next clock edge.
- R3: A jump is accepted when jmp_valid_i is high, stall_i is low and no redirect is pending. After the accepting edge, pc_o is the jump address + 4, which is the delay slot. After the next unstalled edge, pc_o is the captured target.
- R4: For jmp_kind_i 2'b00 (plain immediate) and 2'b01 (immediate with link), the target is {slot[31:28], imm_i, 2'b00}, where slot is the jump address + 4. This holds even when the slot address crosses a 256 MB boundary.
- R5: For jmp_kind_i 2'b10 (plain register) and 2'b11 (register with link), the target is ra_val_i exactly as given.
- R6: For kind 2'b01, one cycle after acceptance wb_en_o is high for exactly one cycle, with wb_idx_o = 31 and wb_data_o = the jump address + 8.
- R7: For kind 2'b11, the write goes to rc_idx_i when rc_given_i is 1 and to index 31 when rc_given_i is 0. The data is the jump address + 8, and the timing is the same as in R6.
- R8: Kinds 2'b00 and 2'b10 never raise wb_en_o.
- R9: A kind 2'b11 jump whose ra_idx_i equals the effective destination index pulses illegal_o for one cycle after acceptance. It does not raise wb_en_o, and it still redirects to ra_val_i.
- R10: A jump presented while a redirect is pending, which is a jump in a delay slot, is ignored. nested_o pulses for one cycle after that edge, there is no link write, and fetch goes to the first jump's target.
- R11: While stall_i is high, pc_o and any pending redirect hold, and jmp_valid_i is ignored. After stall_i drops, the held redirect is taken at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_i | input | 1 | Freeze fetch address and pending redirect |
| jmp_valid_i | input | 1 | Instruction at pc_o is a jump |
| jmp_kind_i | input | 2 | 00 imm, 01 imm+link, 10 reg, 11 reg+link |
| imm_i | input | 26 | Word-index immediate for immediate jumps |
| ra_val_i | input | 32 | Source register value for register jumps |
| ra_idx_i | input | 5 | Source register index |
| rc_idx_i | input | 5 | Link destination index for kind 11 |
| rc_given_i | input | 1 | rc_idx_i is valid; else index 31 is used |
| pc_o | output | 32 | Current fetch address |
| wb_en_o | output | 1 | Return-address write enable, one-cycle pulse |
| wb_idx_o | output | 5 | Return-address destination index |
| wb_data_o | output | 32 | Return address |
| illegal_o | output | 1 | Source/destination collision on kind 11 |
| nested_o | output | 1 | Jump seen in a delay slot |

## Verification
Every result is registered. pc_o, wb_en_o, wb_idx_o, wb_data_o, illegal_o and nested_o all change exactly one edge after the cycle that accepted the jump or saw the event. The redirect to the target appears one further unstalled edge later. The bench drives inputs and samples outputs at the falling edge, so each check reads the value produced by the rising edge just before it. Stall checks sample once per held cycle and then one edge after release.

// File: rtl/jump_unit_pkg.sv
package jump_unit_pkg;
  typedef enum logic [1:0] {
    JK_IMM      = 2'b00,
    JK_IMM_LINK = 2'b01,
    JK_REG      = 2'b10,
    JK_REG_LINK = 2'b11
  } jump_kind_e;

  function automatic logic kind_links(jump_kind_e k);
    return (k == JK_IMM_LINK) || (k == JK_REG_LINK);
  endfunction

  function automatic logic kind_uses_reg(jump_kind_e k);
    return (k == JK_REG) || (k == JK_REG_LINK);
  endfunction
endpackage

// File: rtl/jump_target_gen.sv
module jump_target_gen
  import jump_unit_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 26,
  parameter int SHIFT  = 2,
  localparam int HI_W  = ADDR_W - IMM_W - SHIFT
) (
  input  jump_kind_e        kind_i,
  input  logic [HI_W-1:0]   slot_hi_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ADDR_W-1:0] reg_val_i,
  output logic [ADDR_W-1:0] target_o
);
  logic [ADDR_W-1:0] imm_tgt;

  // region bits come from the delay-slot address, not the jump's own
  assign imm_tgt  = {slot_hi_i, imm_i, {SHIFT{1'b0}}};
  assign target_o = kind_uses_reg(kind_i) ? reg_val_i : imm_tgt;
endmodule

// File: rtl/jump_seq.sv
module jump_seq #(
  parameter int                 ADDR_W   = 32,
  parameter logic [ADDR_W-1:0]  RESET_PC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] seq_pc_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] tgt_o,
  output logic              pend_o,
  output logic              accept_o,
  output logic              nested_o
);
  logic [ADDR_W-1:0] pc_q, tgt_q;
  logic              pend_q, nested_q;
  logic              accept, nest_evt;

  assign accept   = req_i & ~stall_i & ~pend_q;
  assign nest_evt = req_i & ~stall_i &  pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= RESET_PC;
      tgt_q    <= '0;
      pend_q   <= 1'b0;
      nested_q <= 1'b0;
    end else begin
      nested_q <= nest_evt;
      if (!stall_i) begin
        if (pend_q) begin
          pc_q   <= tgt_q;
          pend_q <= 1'b0;
        end else begin
          pc_q <= seq_pc_i;
          if (accept) begin
            tgt_q  <= target_i;
            pend_q <= 1'b1;
          end
        end
      end
    end
  end

  assign pc_o     = pc_q;
  assign tgt_o    = tgt_q;
  assign pend_o   = pend_q;
  assign accept_o = accept;
  assign nested_o = nested_q;
endmodule

// File: rtl/jump_link_gen.sv
module jump_link_gen
  import jump_unit_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 5,
  parameter int LINK_REG = 31
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  jump_kind_e        kind_i,
  input  logic [ADDR_W-1:0] ret_pc_i,
  input  logic [IDX_W-1:0]  ra_idx_i,
  input  logic [IDX_W-1:0]  rc_idx_i,
  input  logic              rc_given_i,
  output logic              wb_en_o,
  output logic [IDX_W-1:0]  wb_idx_o,
  output logic [ADDR_W-1:0] wb_data_o,
  output logic              illegal_o
);
  localparam logic [IDX_W-1:0] LINK_IDX = IDX_W'(LINK_REG);

  logic [IDX_W-1:0]  rc_eff, dest;
  logic              clash, links;
  logic              wb_en_q, ill_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] data_q;

  assign rc_eff = rc_given_i ? rc_idx_i : LINK_IDX;
  assign dest   = (kind_i == JK_REG_LINK) ? rc_eff : LINK_IDX;
  assign clash  = (kind_i == JK_REG_LINK) && (ra_idx_i == rc_eff);
  assign links  = kind_links(kind_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_en_q <= 1'b0;
      ill_q   <= 1'b0;
      idx_q   <= '0;
      data_q  <= '0;
    end else begin
      wb_en_q <= accept_i & links & ~clash;
      ill_q   <= accept_i & clash;
      if (accept_i && links) begin
        idx_q  <= dest;
        data_q <= ret_pc_i;
      end
    end
  end

  assign wb_en_o   = wb_en_q;
  assign wb_idx_o  = idx_q;
  assign wb_data_o = data_q;
  assign illegal_o = ill_q;
endmodule

// File: rtl/jump_unit.sv
module jump_unit
  import jump_unit_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter int                IMM_W       = 26,
  parameter int                IDX_W       = 5,
  parameter int                INSTR_BYTES = 4,
  parameter int                LINK_REG    = 31,
  parameter logic [ADDR_W-1:0] RESET_PC    = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              jmp_valid_i,
  input  logic [1:0]        jmp_kind_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ADDR_W-1:0] ra_val_i,
  input  logic [IDX_W-1:0]  ra_idx_i,
  input  logic [IDX_W-1:0]  rc_idx_i,
  input  logic              rc_given_i,
  output logic [ADDR_W-1:0] pc_o,
  output logic              wb_en_o,
  output logic [IDX_W-1:0]  wb_idx_o,
  output logic [ADDR_W-1:0] wb_data_o,
  output logic              illegal_o,
  output logic              nested_o
);
  localparam int                SHIFT = $clog2(INSTR_BYTES);
  localparam int                HI_W  = ADDR_W - IMM_W - SHIFT;
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(INSTR_BYTES);

  jump_kind_e        kind;
  logic [ADDR_W-1:0] pc_w, slot_pc, ret_pc, target, tgt_w;
  logic              pend_w, accept_w;

  assign kind    = jump_kind_e'(jmp_kind_i);
  assign slot_pc = pc_w + STEP;
  assign ret_pc  = slot_pc + STEP;

  jump_target_gen #(
    .ADDR_W(ADDR_W), .IMM_W(IMM_W), .SHIFT(SHIFT)
  ) u_tgt (
    .kind_i   (kind),
    .slot_hi_i(slot_pc[ADDR_W-1 -: HI_W]),
    .imm_i    (imm_i),
    .reg_val_i(ra_val_i),
    .target_o (target)
  );

  jump_seq #(
    .ADDR_W(ADDR_W), .RESET_PC(RESET_PC)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stall_i (stall_i),
    .req_i   (jmp_valid_i),
    .seq_pc_i(slot_pc),
    .target_i(target),
    .pc_o    (pc_w),
    .tgt_o   (tgt_w),
    .pend_o  (pend_w),
    .accept_o(accept_w),
    .nested_o(nested_o)
  );

  jump_link_gen #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LINK_REG(LINK_REG)
  ) u_link (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept_w),
    .kind_i    (kind),
    .ret_pc_i  (ret_pc),
    .ra_idx_i  (ra_idx_i),
    .rc_idx_i  (rc_idx_i),
    .rc_given_i(rc_given_i),
    .wb_en_o   (wb_en_o),
    .wb_idx_o  (wb_idx_o),
    .wb_data_o (wb_data_o),
    .illegal_o (illegal_o)
  );

  assign pc_o = pc_w;
endmodule

// File: rtl/jump_unit_chk.sv
module jump_unit_chk #(
  parameter int ADDR_W      = 32,
  parameter int INSTR_BYTES = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stall_i,
  input logic              jmp_valid_i,
  input logic              pend_i,
  input logic [ADDR_W-1:0] tgt_i,
  input logic [ADDR_W-1:0] pc_o,
  input logic              wb_en_o,
  input logic [ADDR_W-1:0] wb_data_o,
  input logic              illegal_o,
  input logic              nested_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  p_seq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !jmp_valid_i && !pend_i) |=> pc_o == $past(pc_o) + STEP);

  p_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jmp_valid_i && !stall_i && !pend_i) |=> (pc_o == $past(pc_o) + STEP) && pend_i);

  p_redirect_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && !stall_i) |=> (pc_o == $past(tgt_i)) && !pend_i);

  p_ret_addr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> wb_data_o == pc_o + STEP);

  p_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |=> !wb_en_o);

  p_no_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !wb_en_o);

  p_nested_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i && jmp_valid_i && !stall_i) |=> nested_o && !wb_en_o);

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> (pc_o == $past(pc_o)) && (pend_i == $past(pend_i)));
endmodule

bind jump_unit jump_unit_chk #(
  .ADDR_W(ADDR_W), .INSTR_BYTES(INSTR_BYTES)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stall_i    (stall_i),
  .jmp_valid_i(jmp_valid_i),
  .pend_i     (pend_w),
  .tgt_i      (tgt_w),
  .pc_o       (pc_o),
  .wb_en_o    (wb_en_o),
  .wb_data_o  (wb_data_o),
  .illegal_o  (illegal_o),
  .nested_o   (nested_o)
);

// File: tb/jump_unit_tb_top.sv
`timescale 1ns/1ps
module jump_unit_tb_top;
  localparam logic [1:0] K_J = 2'b00, K_JL = 2'b01, K_R = 2'b10, K_RL = 2'b11;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        stall_i = 1'b0, jmp_valid_i = 1'b0, rc_given_i = 1'b0;
  logic [1:0]  jmp_kind_i = '0;
  logic [25:0] imm_i = '0;
  logic [31:0] ra_val_i = '0;
  logic [4:0]  ra_idx_i = '0, rc_idx_i = '0;
  logic [31:0] pc_o, wb_data_o;
  logic        wb_en_o, illegal_o, nested_o;
  logic [4:0]  wb_idx_o;

  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  jump_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .stall_i(stall_i), .jmp_valid_i(jmp_valid_i),
    .jmp_kind_i(jmp_kind_i), .imm_i(imm_i), .ra_val_i(ra_val_i), .ra_idx_i(ra_idx_i),
    .rc_idx_i(rc_idx_i), .rc_given_i(rc_given_i), .pc_o(pc_o), .wb_en_o(wb_en_o),
    .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o), .illegal_o(illegal_o), .nested_o(nested_o)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] imm_tgt(logic [31:0] jpc, logic [25:0] imm);
    logic [31:0] s = jpc + 32'd4;
    return {s[31:28], imm, 2'b00};
  endfunction

  task automatic issue(logic [1:0] k, logic [25:0] imm, logic [31:0] rv,
                       logic [4:0] ra, logic [4:0] rc, logic rcg);
    jmp_valid_i = 1'b1; jmp_kind_i = k; imm_i = imm; ra_val_i = rv;
    ra_idx_i = ra; rc_idx_i = rc; rc_given_i = rcg;
  endtask

  task automatic clear();
    jmp_valid_i = 1'b0;
  endtask

  // one accepted jump, checks slot, link pulse, error pulse and redirect
  task automatic run_jump(string req, logic [1:0] k, logic [25:0] imm, logic [31:0] rv,
                          logic [4:0] ra, logic [4:0] rc, logic rcg,
                          logic [31:0] tgt, logic exp_wb, logic [4:0] exp_idx, logic exp_ill);
    logic [31:0] p = pc_o;
    issue(k, imm, rv, ra, rc, rcg);
    @(negedge clk);
    clear();
    chk(req, "slot pc", pc_o, p + 32'd4);
    chk(req, "wb_en", {31'd0, wb_en_o}, {31'd0, exp_wb});
    if (exp_wb) begin
      chk(req, "wb_idx", {27'd0, wb_idx_o}, {27'd0, exp_idx});
      chk(req, "wb_data", wb_data_o, p + 32'd8);
    end
    chk(req, "illegal", {31'd0, illegal_o}, {31'd0, exp_ill});
    @(negedge clk);
    chk(req, "target pc", pc_o, tgt);
    chk(req, "wb_en after pulse", {31'd0, wb_en_o}, 32'd0);
    chk(req, "illegal after pulse", {31'd0, illegal_o}, 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "pc in reset", pc_o, 32'h0);
    chk("R1", "flags in reset", {29'd0, wb_en_o, illegal_o, nested_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R2", "pc after one edge", pc_o, 32'd4);
    @(negedge clk);
    chk("R2", "pc after two edges", pc_o, 32'd8);
  endtask

  task automatic t_imm_jump();
    logic [31:0] p = pc_o;
    run_jump("R4/R8 plain imm", K_J, 26'h123456, 32'hdead_beef, 5'd1, 5'd2, 1'b1,
             imm_tgt(p, 26'h123456), 1'b0, 5'd0, 1'b0);
    p = pc_o;
    @(negedge clk);
    chk("R2", "sequential after redirect", pc_o, p + 32'd4);
  endtask

  task automatic t_reg_jump_and_boundary();
    run_jump("R5/R8 plain reg", K_R, 26'h0, 32'h0fff_fff8, 5'd4, 5'd0, 1'b0,
             32'h0fff_fff8, 1'b0, 5'd0, 1'b0);
    @(negedge clk);
    chk("R2", "pc before boundary", pc_o, 32'h0fff_fffc);
    // slot crosses into 0x1xxx_xxxx region
    run_jump("R4/R6 boundary link", K_JL, 26'h40, 32'h0, 5'd0, 5'd0, 1'b0,
             32'h1000_0100, 1'b1, 5'd31, 1'b0);
  endtask

  task automatic t_reg_link();
    run_jump("R7 given rc", K_RL, 26'h0, 32'h8000_0010, 5'd3, 5'd7, 1'b1,
             32'h8000_0010, 1'b1, 5'd7, 1'b0);
    run_jump("R7 default rc", K_RL, 26'h0, 32'h0000_2000, 5'd5, 5'd7, 1'b0,
             32'h0000_2000, 1'b1, 5'd31, 1'b0);
  endtask

  task automatic t_illegal();
    run_jump("R9 rc equals ra", K_RL, 26'h0, 32'h0000_3000, 5'd9, 5'd9, 1'b1,
             32'h0000_3000, 1'b0, 5'd0, 1'b1);
    run_jump("R9 default rc equals ra", K_RL, 26'h0, 32'h0000_4000, 5'd31, 5'd2, 1'b0,
             32'h0000_4000, 1'b0, 5'd0, 1'b1);
  endtask

  task automatic t_nested();
    logic [31:0] p = pc_o;
    issue(K_R, 26'h0, 32'h0000_5000, 5'd1, 5'd0, 1'b0);
    @(negedge clk);
    chk("R10", "slot pc", pc_o, p + 32'd4);
    issue(K_JL, 26'h0badd, 32'h0, 5'd0, 5'd0, 1'b0);
    @(negedge clk);
    clear();
    chk("R10", "first target kept", pc_o, 32'h0000_5000);
    chk("R10", "nested pulse", {31'd0, nested_o}, 32'd1);
    chk("R10", "no link write", {31'd0, wb_en_o}, 32'd0);
    @(negedge clk);
    chk("R10", "nested drops", {31'd0, nested_o}, 32'd0);
    chk("R10", "sequential after", pc_o, 32'h0000_5004);
    chk("R10", "still no write", {31'd0, wb_en_o}, 32'd0);
  endtask

  task automatic t_stall();
    logic [31:0] p = pc_o;
    stall_i = 1'b1;
    @(negedge clk);
    chk("R11", "seq pc frozen", pc_o, p);
    stall_i = 1'b0;
    @(negedge clk);
    chk("R11", "seq resumes", pc_o, p + 32'd4);
    p = pc_o;
    issue(K_JL, 26'h2222, 32'h0, 5'd0, 5'd0, 1'b0);
    @(negedge clk);
    chk("R11", "slot pc", pc_o, p + 32'd4);
    chk("R11", "link pulse", {31'd0, wb_en_o}, 32'd1);
    stall_i = 1'b1;
    issue(K_R, 26'h0, 32'h0000_7770, 5'd1, 5'd0, 1'b0); // ignored while stalled
    @(negedge clk);
    chk("R11", "slot held 1", pc_o, p + 32'd4);
    chk("R11", "pulse single", {31'd0, wb_en_o}, 32'd0);
    chk("R11", "stalled jump ignored", {31'd0, nested_o}, 32'd0);
    @(negedge clk);
    chk("R11", "slot held 2", pc_o, p + 32'd4);
    clear();
    stall_i = 1'b0;
    @(negedge clk);
    chk("R11", "redirect after release", pc_o, imm_tgt(p, 26'h2222));
    chk("R11", "no late write", {31'd0, wb_en_o}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_imm_jump();
    t_reg_jump_and_boundary();
    t_reg_link();
    t_illegal();
    t_nested();
    t_stall();
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule